// File: doc/BRIEF.md
# Table-Driven Microprogram Sequencer

This block steps through a writable control store of 36-bit microwords. It keeps a 12-bit sequence counter that points at the next word to fetch and a microword register that holds the word now executing. Each microword picks one of five sequencing actions: step, step with a special command, stall until a bus operation completes, branch, or jump on a selected condition. There is no return stack, so the counter changes only by stepping, branching or jumping.

Multi-way decoding goes through a small decode table of 8-bit entries arranged in rows of sixteen. The column is one of four 4-bit fields of a 16-bit extension register, and the row comes from a row register. A fetched entry either gives the low eight bits of a branch target or names the row for the next lookup. The extension register also provides a 4-bit mask that can be ANDed into the next microword's address field, and its low nibble serves as a loop counter for shift commands. The control store and the table are written through plain write ports, normally while reset is held. The ALU and bus datapaths sit outside this block and read the executing microword from `uinst`.

Top module: `tbl_useq`

## Requirements
- R1: While `rst_n` is low, `seq_addr`, `uinst`, `ext_q` and `row_q` read zero, and zero in `uinst` decodes as a plain step. The first edge after release fetches control-store word 0, leaving `seq_addr` at 1.
- R2: The sequence code sits in microword bits [35:33]. Codes 0, 5, 6 and 7 step: the word at `seq_addr` is fetched and `seq_addr` increases by one.
- R3: Code 1 steps and raises `cmd_valid` with `cmd_code` = bits [32:30]. Command 2 loads the extension register from `ext_din`. Command 3 loads the row register from the low four bits of the address field, which occupies bits [19:8].
- R4: Command 1 (shift) adds one to `ext_q[3:0]`, wrapping from 15 to 0, and leaves `ext_q[15:4]` unchanged.
- R5: Code 2 holds `seq_addr`, `uinst` and all other state for as long as `bus_done` is low. In a cycle with `bus_done` high it steps.
- R6: Code 3 branches. If bit 27 is 0, the target is the effective address field. If bit 27 is 1, the target is the effective field's bits [11:8] joined with the 8-bit table entry.
- R7: Code 4 jumps to the effective address field when `cond_in[bits 22:20]` XOR bit 23 is 1. Otherwise it steps.
- R8: The table read index is the row register followed by the extension field that bits [29:28] select. Field k is `ext_q[4k+3:4k]`.
- R9: When bit 26 is set, the row register takes the low four bits of the table entry. Command 3 overrides this in the same word.
- R10: When bit 25 is set, the next microword's address-field low nibble is ANDed with `ext_q[15:12]` if bit 24 is 1, or with `ext_q[7:4]` if bit 24 is 0. Otherwise no mask applies.
- R11: A table lookup or mask selection in a cycle uses the extension and row values from before that cycle's own updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 10 | Control-store write address |
| cs_wdata | input | 36 | Control-store write data |
| tbl_we | input | 1 | Decode-table write enable |
| tbl_waddr | input | 8 | Decode-table write address |
| tbl_wdata | input | 8 | Decode-table write data |
| bus_done | input | 1 | Bus operation complete |
| cond_in | input | 8 | Condition inputs for jumps |
| ext_din | input | 16 | Load value for the extension register |
| uinst | output | 36 | Executing microword |
| seq_addr | output | 12 | Sequence counter (next fetch address) |
| ext_q | output | 16 | Extension register |
| row_q | output | 4 | Decode-table row register |
| cmd_valid | output | 1 | Special command issued this cycle |
| cmd_code | output | 3 | Special command code |

## Verification
A shift command can carry a row-load lookup in the same word whose column is the loop-counter nibble. The bench sets this up with a row of 7 and a loop counter of 2, so entry 0x72 must supply the new row. Had the incremented counter been used, entry 0x73 would give a different row, and `row_q` is compared after that edge. A second overlap, a row-set command together with a row-load flag, is checked after reset to confirm that the command takes priority.

// File: rtl/useq_pkg.sv
package useq_pkg;
   localparam int UW       = 36;
   localparam int SA_W     = 12;
   localparam int ENT_W    = 8;
   localparam int EXT_W    = 16;
   localparam int NIB      = 4;
   localparam int NFLD     = EXT_W / NIB;
   localparam int FSEL_W   = $clog2(NFLD);
   localparam int SEQ_W    = 3;
   localparam int CMD_W    = 3;
   localparam int CSEL_W   = 3;
   localparam int NCOND    = 1 << CSEL_W;
   localparam int PAGE_LEN = 1 << ENT_W;
   localparam int AND_LO_F = 1;
   localparam int AND_HI_F = 3;
   localparam int SPARE_W  = UW - (SEQ_W + CMD_W + FSEL_W + 5 + CSEL_W + SA_W);

   localparam logic [SEQ_W-1:0] SQ_NEXT   = 3'd0;
   localparam logic [SEQ_W-1:0] SQ_CMD    = 3'd1;
   localparam logic [SEQ_W-1:0] SQ_WAIT   = 3'd2;
   localparam logic [SEQ_W-1:0] SQ_BRANCH = 3'd3;
   localparam logic [SEQ_W-1:0] SQ_JUMP   = 3'd4;

   localparam logic [CMD_W-1:0] CM_SHIFT  = 3'd1;
   localparam logic [CMD_W-1:0] CM_LOADX  = 3'd2;
   localparam logic [CMD_W-1:0] CM_SETROW = 3'd3;

   typedef struct packed {
      logic [SEQ_W-1:0]   seq;
      logic [CMD_W-1:0]   cmd;
      logic [FSEL_W-1:0]  fsel;
      logic               tuse;
      logic               rowld;
      logic               and_en;
      logic               and_hi;
      logic               pol;
      logic [CSEL_W-1:0]  csel;
      logic [SA_W-1:0]    addr;
      logic [SPARE_W-1:0] spare;
   } uword_t;
endpackage

// File: rtl/useq_mem.sv
module useq_mem #(
   parameter int W     = 8,
   parameter int DEPTH = 256
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [W-1:0]             wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [W-1:0]             rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
   import useq_pkg::*;
(
   input  logic [SEQ_W-1:0]  seq,
   input  logic              tuse,
   input  logic              pol,
   input  logic [CSEL_W-1:0] csel,
   input  logic [SA_W-1:0]   addr,
   input  logic [NIB-1:0]    mask,
   input  logic [SA_W-1:0]   seq_q,
   input  logic [ENT_W-1:0]  entry,
   input  logic [NCOND-1:0]  cond_in,
   input  logic              bus_done,
   output logic [SA_W-1:0]   na,
   output logic              adv
);
   logic [SA_W-1:0] a_eff;
   logic [SA_W-1:0] t_tgt;
   logic            take;

   // low nibble of the literal target is gated by the pending mask
   assign a_eff = {addr[SA_W-1:NIB], addr[NIB-1:0] & mask};
   // table target keeps the page of the literal field
   assign t_tgt = {a_eff[SA_W-1:ENT_W], entry};
   assign take  = cond_in[csel] ^ pol;

   always_comb begin
      adv = 1'b1;
      na  = seq_q;
      case (seq)
         SQ_WAIT:   adv = bus_done;
         SQ_BRANCH: na  = tuse ? t_tgt : a_eff;
         SQ_JUMP:   if (take) na = a_eff;
         default:   ;
      endcase
   end
endmodule

// File: rtl/useq_xreg.sv
module useq_xreg
   import useq_pkg::*;
#(
   parameter int ROW_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              is_cmd,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [FSEL_W-1:0] fsel,
   input  logic              rowld,
   input  logic              and_en,
   input  logic              and_hi,
   input  logic [ROW_W-1:0]  row_lit,
   input  logic [ROW_W-1:0]  row_tbl,
   input  logic [EXT_W-1:0]  ext_din,
   output logic [EXT_W-1:0]  ext_q,
   output logic [ROW_W-1:0]  row_q,
   output logic [NIB-1:0]    mask_q,
   output logic [NIB-1:0]    fld
);
   logic [NIB-1:0] nib [NFLD];

   for (genvar g = 0; g < NFLD; g++) begin : g_nib
      assign nib[g] = ext_q[g*NIB +: NIB];
   end

   assign fld = nib[fsel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_q  <= '0;
         row_q  <= '0;
         mask_q <= '1;
      end else if (adv) begin
         mask_q <= and_en ? (and_hi ? nib[AND_HI_F] : nib[AND_LO_F]) : '1;
         if (is_cmd && cmd == CM_LOADX)
            ext_q <= ext_din;
         else if (is_cmd && cmd == CM_SHIFT)
            ext_q[NIB-1:0] <= ext_q[NIB-1:0] + 1'b1;
         if (is_cmd && cmd == CM_SETROW)
            row_q <= row_lit;
         else if (rowld)
            row_q <= row_tbl;
      end
   end
endmodule

// File: rtl/tbl_useq.sv
module tbl_useq
   import useq_pkg::*;
#(
   parameter int CS_DEPTH  = 1024,
   parameter int TBL_DEPTH = 256,
   parameter int ROW_LEN   = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cs_we,
   input  logic [$clog2(CS_DEPTH)-1:0] cs_waddr,
   input  logic [UW-1:0]               cs_wdata,
   input  logic                        tbl_we,
   input  logic [$clog2(TBL_DEPTH)-1:0] tbl_waddr,
   input  logic [ENT_W-1:0]            tbl_wdata,
   input  logic                        bus_done,
   input  logic [NCOND-1:0]            cond_in,
   input  logic [EXT_W-1:0]            ext_din,
   output logic [UW-1:0]               uinst,
   output logic [SA_W-1:0]             seq_addr,
   output logic [EXT_W-1:0]            ext_q,
   output logic [$clog2(TBL_DEPTH)-$clog2(ROW_LEN)-1:0] row_q,
   output logic                        cmd_valid,
   output logic [CMD_W-1:0]            cmd_code
);
   localparam int CS_AW  = $clog2(CS_DEPTH);
   localparam int TBL_AW = $clog2(TBL_DEPTH);
   localparam int COL_W  = $clog2(ROW_LEN);
   localparam int ROW_W  = TBL_AW - COL_W;

   initial begin
      assert (ROW_LEN == (1 << NIB))
         else $error("row length must match one extension field");
      assert (CS_DEPTH % PAGE_LEN == 0 && CS_DEPTH <= (1 << SA_W))
         else $error("control store must be whole pages within the counter range");
      assert (ROW_W >= 1 && ROW_W <= ENT_W && ROW_W <= NIB)
         else $error("row index must fit in a table entry and a nibble");
   end

   uword_t          mw;
   logic [SA_W-1:0] seq_q;
   logic [SA_W-1:0] na;
   logic            adv;
   logic            is_cmd;
   logic [UW-1:0]   cs_rd;
   logic [ENT_W-1:0] entry;
   logic [NIB-1:0]  mask_q;
   logic [NIB-1:0]  fld;
   logic [TBL_AW-1:0] tbl_ra;

   assign is_cmd = (mw.seq == SQ_CMD);
   assign tbl_ra = {row_q, fld};

   useq_mem #(.W(UW), .DEPTH(CS_DEPTH)) u_cs (
      .clk(clk), .we(cs_we), .waddr(cs_waddr), .wdata(cs_wdata),
      .raddr(na[CS_AW-1:0]), .rdata(cs_rd)
   );

   useq_mem #(.W(ENT_W), .DEPTH(TBL_DEPTH)) u_tbl (
      .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
      .raddr(tbl_ra), .rdata(entry)
   );

   useq_nextaddr u_na (
      .seq(mw.seq), .tuse(mw.tuse), .pol(mw.pol), .csel(mw.csel),
      .addr(mw.addr), .mask(mask_q), .seq_q(seq_q), .entry(entry),
      .cond_in(cond_in), .bus_done(bus_done), .na(na), .adv(adv)
   );

   useq_xreg #(.ROW_W(ROW_W)) u_x (
      .clk(clk), .rst_n(rst_n), .adv(adv), .is_cmd(is_cmd), .cmd(mw.cmd),
      .fsel(mw.fsel), .rowld(mw.rowld), .and_en(mw.and_en), .and_hi(mw.and_hi),
      .row_lit(mw.addr[ROW_W-1:0]), .row_tbl(entry[ROW_W-1:0]),
      .ext_din(ext_din), .ext_q(ext_q), .row_q(row_q), .mask_q(mask_q), .fld(fld)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_q <= '0;
         mw    <= '0;
      end else if (adv) begin
         seq_q <= na + 1'b1;
         mw    <= uword_t'(cs_rd);
      end
   end

   assign uinst     = mw;
   assign seq_addr  = seq_q;
   assign cmd_valid = is_cmd;
   assign cmd_code  = mw.cmd;
endmodule

// File: rtl/tbl_useq_chk.sv
module tbl_useq_chk
   import useq_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic [UW-1:0]    uinst,
   input logic [SA_W-1:0]  seq_addr,
   input logic [EXT_W-1:0] ext_q,
   input logic [3:0]       row_q,
   input logic             bus_done,
   input logic [NCOND-1:0] cond_in
);
   uword_t w;
   assign w = uword_t'(uinst);

   logic unused_flds;
   assign unused_flds = ^{w.spare, w.fsel, w.tuse, w.and_en, w.and_hi, w.addr};

   // R2
   step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w.seq == SQ_NEXT) |=> seq_addr == $past(seq_addr) + 12'd1);

   // R4
   shift_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w.seq == SQ_CMD && w.cmd == CM_SHIFT) |=>
         (ext_q[3:0] == $past(ext_q[3:0]) + 4'd1) && (ext_q[15:4] == $past(ext_q[15:4])));

   // R3
   ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w.seq != SQ_CMD) |=> $stable(ext_q));

   // R5
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w.seq == SQ_WAIT && !bus_done) |=> $stable(seq_addr) && $stable(uinst));

   // R7
   jump_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w.seq == SQ_JUMP && !(cond_in[w.csel] ^ w.pol)) |=> seq_addr == $past(seq_addr) + 12'd1);

   // R9
   row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!w.rowld && !(w.seq == SQ_CMD && w.cmd == CM_SETROW)) |=> $stable(row_q));
endmodule

bind tbl_useq tbl_useq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .uinst(uinst), .seq_addr(seq_addr),
   .ext_q(ext_q), .row_q(row_q), .bus_done(bus_done), .cond_in(cond_in)
);

// File: tb/sim_tbl_useq.sv
module sim_tbl_useq;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cs_we;
   logic [9:0]  cs_waddr;
   logic [35:0] cs_wdata;
   logic        tbl_we;
   logic [7:0]  tbl_waddr;
   logic [7:0]  tbl_wdata;
   logic        bus_done;
   logic [7:0]  cond_in;
   logic [15:0] ext_din;
   logic [35:0] uinst;
   logic [11:0] seq_addr;
   logic [15:0] ext_q;
   logic [3:0]  row_q;
   logic        cmd_valid;
   logic [2:0]  cmd_code;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   tbl_useq u0 (
      .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
      .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
      .bus_done(bus_done), .cond_in(cond_in), .ext_din(ext_din),
      .uinst(uinst), .seq_addr(seq_addr), .ext_q(ext_q), .row_q(row_q),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code)
   );

   // vector: bus_done[40], cond_in[39:32], seq_addr[31:20], ext_q[19:4], row_q[3:0]
   localparam int NV = 14;
   localparam logic [40:0] VEC [NV] = '{
      {1'b0, 8'h00, 12'h001, 16'h0000, 4'h0},
      {1'b0, 8'h00, 12'h002, 16'h3A52, 4'h0},
      {1'b0, 8'h00, 12'h003, 16'h3A52, 4'h7},
      {1'b0, 8'h00, 12'h004, 16'h3A53, 4'hF},
      {1'b0, 8'h00, 12'h06F, 16'h3A53, 4'hF},
      {1'b0, 8'h04, 12'h021, 16'h3A53, 4'hF},
      {1'b0, 8'h00, 12'h036, 16'h3A53, 4'hF},
      {1'b0, 8'h00, 12'h036, 16'h3A53, 4'hF},
      {1'b0, 8'h00, 12'h036, 16'h3A53, 4'hF},
      {1'b1, 8'h00, 12'h037, 16'h3A53, 4'hF},
      {1'b0, 8'h00, 12'h038, 16'h3A53, 4'hF},
      {1'b0, 8'h00, 12'h201, 16'h3A53, 4'hF},
      {1'b0, 8'h00, 12'h202, 16'h3A54, 4'hF},
      {1'b0, 8'h00, 12'h202, 16'h3A54, 4'hF}
   };

   function automatic string vtag(input int k);
      case (k)
         0:       return "R1 R2";
         1, 2:    return "R3 R2";
         3:       return "R4 R9 R11 R8";
         4:       return "R6 R8";
         5:       return "R7";
         6:       return "R10 R6";
         7, 8, 9: return "R5";
         10, 11:  return "R7";
         12:      return "R4";
         default: return "R6";
      endcase
   endfunction

   function automatic logic [35:0] mk(input int sq, input int cm, input int fs, input int tu,
                                      input int rl, input int ae, input int ah, input int pl,
                                      input int cs, input int ad);
      return {3'(sq), 3'(cm), 2'(fs), 1'(tu), 1'(rl), 1'(ae), 1'(ah), 1'(pl), 3'(cs), 12'(ad), 8'h00};
   endfunction

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_cs(input int a, input logic [35:0] d);
      cs_we    = 1'b1;
      cs_waddr = 10'(a);
      cs_wdata = d;
      @(negedge clk);
      cs_we    = 1'b0;
   endtask

   task automatic wr_tbl(input int a, input logic [7:0] d);
      tbl_we    = 1'b1;
      tbl_waddr = 8'(a);
      tbl_wdata = d;
      @(negedge clk);
      tbl_we    = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cs_we = 1'b0; cs_waddr = '0; cs_wdata = '0;
      tbl_we = 1'b0; tbl_waddr = '0; tbl_wdata = '0;
      bus_done = 1'b0; cond_in = '0; ext_din = 16'h3A52;
      @(negedge clk);
      for (int i = 0; i < 1024; i++) wr_cs(i, 36'h0);
      for (int i = 0; i < 256; i++) wr_tbl(i, 8'(i * 37 + 5));
      wr_cs(12'h000, mk(1, 2, 0, 0, 0, 0, 0, 0, 0, 12'h000));
      wr_cs(12'h001, mk(1, 3, 0, 0, 0, 0, 0, 0, 0, 12'h007));
      wr_cs(12'h002, mk(1, 1, 0, 0, 1, 0, 0, 0, 0, 12'h000));
      wr_cs(12'h003, mk(3, 0, 1, 1, 0, 0, 0, 0, 0, 12'h000));
      wr_cs(12'h06E, mk(4, 0, 0, 0, 0, 1, 0, 0, 2, 12'h020));
      wr_cs(12'h020, mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 12'h03F));
      wr_cs(12'h035, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 12'h000));
      wr_cs(12'h036, mk(4, 0, 0, 0, 0, 0, 0, 0, 2, 12'h100));
      wr_cs(12'h037, mk(4, 0, 0, 0, 0, 0, 0, 1, 5, 12'h200));
      wr_cs(12'h200, mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 12'h000));
      wr_cs(12'h201, mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 12'h201));

      // R1 reset state
      check("R1 seq_addr", 36'(seq_addr), 36'h0);
      check("R1 uinst", uinst, 36'h0);
      check("R1 ext_q", 36'(ext_q), 36'h0);
      check("R1 row_q", 36'(row_q), 36'h0);

      rst_n = 1'b1;
      for (int k = 0; k < NV; k++) begin
         bus_done = VEC[k][40];
         cond_in  = VEC[k][39:32];
         @(posedge clk);
         @(negedge clk);
         check({vtag(k), " seq_addr"}, 36'(seq_addr), 36'(VEC[k][31:20]));
         check({vtag(k), " ext_q"},    36'(ext_q),    36'(VEC[k][19:4]));
         check({vtag(k), " row_q"},    36'(row_q),    36'(VEC[k][3:0]));
      end
      bus_done = 1'b0;
      cond_in  = '0;

      // second reset: row-set command together with a row-load flag
      rst_n = 1'b0;
      wr_cs(12'h000, mk(1, 3, 0, 0, 1, 0, 0, 0, 0, 12'h009));
      wr_cs(12'h001, 36'h0);
      check("R1 seq_addr after reset", 36'(seq_addr), 36'h0);
      check("R1 uinst after reset", uinst, 36'h0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R1 first fetch seq_addr", 36'(seq_addr), 36'h1);
      check("R1 first fetch uinst", uinst, mk(1, 3, 0, 0, 1, 0, 0, 0, 0, 12'h009));
      @(posedge clk);
      @(negedge clk);
      check("R9 command wins over row load", 36'(row_q), 36'h9);
      check("R2 step after command", 36'(seq_addr), 36'h2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule